// File: doc/BRIEF.md
# Execution Halt Condition Monitor

This block sits beside a processor's retire port and decides when program execution has to stop. Each retire event carries the program counter sampled before the instruction and the one that follows it. It also carries a flag marking an IDLE instruction and a pending-interrupt line. From these the monitor tracks four stop causes:

- an enabled stop address matches the pre-execution PC;
- the instruction leaves the PC unchanged, which is a self-loop;
- an IDLE instruction is not woken by an interrupt;
- the executed-instruction count reaches a programmable limit.

When a cause fires, the monitor raises a halt flag and latches a two-bit reason code. The halt flag, the reason code and the step count all hold until a synchronous clear. A test harness loads the step limit and the stop-address slots, releases the processor, and waits for the halt flag. It then reads the reason code and the number of instructions executed.

Steps are numbered from zero. The index of a retiring instruction equals the value on `steps_o` just before it retires. After the halt, `steps_o` gives the number of instructions that executed.

Top module: `halt_monitor`

## Requirements
- R1: After reset, `halt_o` is 0, `reason_o` is 0, `steps_o` is 0, the step limit is 1,000,000 and all four stop slots are disabled.
- R2: Each accepted retire that is not a stop-address hit adds one to `steps_o` in the cycle after it, and no halt is raised while no cause fires.
- R3: An accepted retire that brings the step count to the limit or above raises `halt_o` in the next cycle with reason code 3 (max). The limit is written through `lim_we_i`/`lim_i`.
- R4: A stop slot is written through `slot_we_i`, `slot_idx_i`, `slot_addr_i` and `slot_en_i`. An accepted retire whose `pc_pre_i` equals the address of an enabled slot raises `halt_o` next cycle with reason code 1 (stop), and that instruction is not counted.
- R5: A slot whose enable bit is 0 never matches, whatever its address.
- R6: An accepted retire with `pc_post_i` equal to `pc_pre_i` raises `halt_o` next cycle with reason code 2 (loop). The instruction is counted.
- R7: An accepted IDLE retire (`idle_i`=1) with `irq_i`=0 opens a one-cycle window. If `irq_i` is 0 in that window, `halt_o` rises at the end of the window with reason code 0 (idle), two cycles after the retire was sampled.
- R8: If `irq_i` is 1 together with the IDLE retire or during its window, the idle halt is cancelled and later retires are processed normally.
- R9: When several causes fire on one retire, the order is stop > loop > idle > max. If an IDLE retire also reaches the limit, the result is idle when no interrupt comes in the window, and max when one does.
- R10: While `halt_o` is 1, `reason_o` and `steps_o` stay unchanged and retires are ignored.
- R11: `clear_i` clears `halt_o`, `reason_o`, `steps_o` and any open idle window on the next clock edge. The step limit and the stop slots keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of halt state and step count |
| lim_we_i | input | 1 | Write strobe for the step limit |
| lim_i | input | CW | New step limit |
| slot_we_i | input | 1 | Write strobe for one stop slot |
| slot_idx_i | input | SIW | Stop slot selected for writing |
| slot_addr_i | input | AW | Stop address to store |
| slot_en_i | input | 1 | Enable bit to store |
| retire_i | input | 1 | One instruction retires this cycle |
| pc_pre_i | input | AW | PC before the instruction |
| pc_post_i | input | AW | PC after the instruction |
| idle_i | input | 1 | Retiring instruction is IDLE |
| irq_i | input | 1 | Interrupt pending |
| halt_o | output | 1 | Execution must stop |
| reason_o | output | 2 | 0 idle, 1 stop, 2 loop, 3 max |
| steps_o | output | CW | Instructions executed since reset or clear |

## Verification
Plain retires with advancing PCs are checked to count without halting. A short limit then shows that the max halt comes on the exact retire that reaches it. Stop addresses are tried in both an enabled and a disabled slot, which separates the address compare from the enable bit. The idle test sends the interrupt in three ways: absent, together with the IDLE retire, and one cycle later. This separates a committed idle from both cancellation paths. Retires that raise two causes at once (a stop address that is also a self-loop, an IDLE that is also a self-loop, and an IDLE on the final step with and without a wakeup) pin down the priority order.

// File: rtl/hm_pkg.sv
package hm_pkg;
  typedef enum logic [1:0] {
    RSN_IDLE = 2'd0,
    RSN_STOP = 2'd1,
    RSN_LOOP = 2'd2,
    RSN_MAX  = 2'd3
  } reason_e;
endpackage

// File: rtl/hm_stop_table.sv
module hm_stop_table #(
  parameter int AW    = 16,
  parameter int NSLOT = 4,
  localparam int SIW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [SIW-1:0] idx_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           en_i,
  input  logic [AW-1:0]  pc_i,
  output logic           hit_o
);
  logic [NSLOT-1:0] match;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [AW-1:0] addr_q;
    logic          en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        en_q   <= 1'b0;
      end else if (we_i && idx_i == SIW'(g)) begin
        addr_q <= addr_i;
        en_q   <= en_i;
      end
    end
    assign match[g] = en_q && (addr_q == pc_i);

    // R5: a disabled slot contributes nothing
    a_r5_disabled_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q |-> !match[g]);
  end

  assign hit_o = |match;
endmodule

// File: rtl/hm_step_counter.sv
module hm_step_counter #(
  parameter int            CW        = 32,
  parameter logic [CW-1:0] DEF_LIMIT = CW'(1_000_000)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          inc_i,
  input  logic          lim_we_i,
  input  logic [CW-1:0] lim_i,
  output logic [CW-1:0] count_o,
  output logic          reach_o
);
  logic [CW-1:0] count_q, limit_q;
  logic [CW:0]   next_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) limit_q <= DEF_LIMIT;
    else if (lim_we_i) limit_q <= lim_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (inc_i) count_q <= count_q + 1'b1;
  end

  // reach_o: this retire, once counted, meets the limit
  assign next_cnt = {1'b0, count_q} + 1'b1;
  assign reach_o  = next_cnt >= {1'b0, limit_q};
  assign count_o  = count_q;

  a_r11_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);
  a_r10_hold_without_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !inc_i |=> $stable(count_o));
endmodule

// File: rtl/hm_idle_guard.sv
module hm_idle_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic arm_i,
  input  logic arm_max_i,
  input  logic irq_i,
  output logic pend_o,
  output logic commit_idle_o,
  output logic commit_max_o,
  output logic open_o
);
  logic pend_q, pend_max_q;

  // window lasts exactly one cycle; a new arm can only come from a woken core
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_max_q <= 1'b0;
    end else if (clear_i) begin
      pend_q     <= 1'b0;
      pend_max_q <= 1'b0;
    end else begin
      pend_q     <= arm_i;
      pend_max_q <= arm_i && arm_max_i;
    end
  end

  assign pend_o        = pend_q;
  assign commit_idle_o = pend_q && !irq_i;
  assign commit_max_o  = pend_q && irq_i && pend_max_q;
  assign open_o        = !pend_q || (irq_i && !pend_max_q);

  a_r7_arm_opens_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i && !clear_i |=> pend_o);
endmodule

// File: rtl/halt_monitor.sv
module halt_monitor #(
  parameter int            AW        = 16,
  parameter int            CW        = 32,
  parameter int            NSLOT     = 4,
  parameter logic [CW-1:0] DEF_LIMIT = CW'(1_000_000),
  localparam int           SIW       = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           lim_we_i,
  input  logic [CW-1:0]  lim_i,
  input  logic           slot_we_i,
  input  logic [SIW-1:0] slot_idx_i,
  input  logic [AW-1:0]  slot_addr_i,
  input  logic           slot_en_i,
  input  logic           retire_i,
  input  logic [AW-1:0]  pc_pre_i,
  input  logic [AW-1:0]  pc_post_i,
  input  logic           idle_i,
  input  logic           irq_i,
  output logic           halt_o,
  output logic [1:0]     reason_o,
  output logic [CW-1:0]  steps_o
);
  import hm_pkg::*;

  logic    halt_q;
  reason_e reason_q;
  logic    table_hit, reach, pend, commit_idle, commit_max, open;
  logic    acc, stop_hit, loop_hit, idle_now, arm, max_fire, inc;

  hm_stop_table #(.AW(AW), .NSLOT(NSLOT)) u_table (
    .clk_i, .rst_ni,
    .we_i(slot_we_i), .idx_i(slot_idx_i), .addr_i(slot_addr_i), .en_i(slot_en_i),
    .pc_i(pc_pre_i), .hit_o(table_hit)
  );

  hm_step_counter #(.CW(CW), .DEF_LIMIT(DEF_LIMIT)) u_count (
    .clk_i, .rst_ni, .clear_i, .inc_i(inc),
    .lim_we_i, .lim_i, .count_o(steps_o), .reach_o(reach)
  );

  hm_idle_guard u_idle (
    .clk_i, .rst_ni, .clear_i,
    .arm_i(arm), .arm_max_i(reach), .irq_i,
    .pend_o(pend), .commit_idle_o(commit_idle), .commit_max_o(commit_max), .open_o(open)
  );

  always_comb begin
    acc      = retire_i && !halt_q && open && !clear_i;
    stop_hit = acc && table_hit;
    loop_hit = acc && !table_hit && (pc_post_i == pc_pre_i);
    idle_now = acc && !table_hit && !loop_hit && idle_i;
    arm      = idle_now && !irq_i;
    max_fire = acc && !table_hit && !loop_hit && !arm && reach;
    inc      = acc && !table_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q   <= 1'b0;
      reason_q <= RSN_IDLE;
    end else if (clear_i) begin
      halt_q   <= 1'b0;
      reason_q <= RSN_IDLE;
    end else if (!halt_q) begin
      if (commit_idle) begin
        halt_q <= 1'b1; reason_q <= RSN_IDLE;
      end else if (commit_max) begin
        halt_q <= 1'b1; reason_q <= RSN_MAX;
      end else if (stop_hit) begin
        halt_q <= 1'b1; reason_q <= RSN_STOP;
      end else if (loop_hit) begin
        halt_q <= 1'b1; reason_q <= RSN_LOOP;
      end else if (max_fire) begin
        halt_q <= 1'b1; reason_q <= RSN_MAX;
      end
    end
  end

  assign halt_o   = halt_q;
  assign reason_o = reason_q;

  a_r10_halt_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !clear_i |=> halt_o && $stable(reason_o) && $stable(steps_o));
  a_r11_clear_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !halt_o && reason_o == 2'd0);
  a_r4_stop_not_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && !halt_o && !pend && table_hit && !clear_i
    |=> halt_o && reason_o == 2'd1 && $stable(steps_o));
  a_r9_loop_over_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && !halt_o && !pend && !table_hit && pc_post_i == pc_pre_i && !clear_i
    |=> halt_o && reason_o == 2'd2);
  a_r8_irq_cancels_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_o && retire_i && idle_i && irq_i && !pend && !table_hit && !reach
    && pc_post_i != pc_pre_i && !clear_i |=> !halt_o);
endmodule

// File: tb/tb_halt_monitor.sv
module tb_halt_monitor;
  localparam int AW = 16, CW = 32;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          clear_i = 0, lim_we_i = 0, slot_we_i = 0, slot_en_i = 0;
  logic [CW-1:0] lim_i = '0;
  logic [1:0]    slot_idx_i = '0;
  logic [AW-1:0] slot_addr_i = '0, pc_pre_i = '0, pc_post_i = '0;
  logic          retire_i = 0, idle_i = 0, irq_i = 0;
  logic          halt_o;
  logic [1:0]    reason_o;
  logic [CW-1:0] steps_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  halt_monitor dut (
    .clk_i(clk), .rst_ni, .clear_i, .lim_we_i, .lim_i, .slot_we_i, .slot_idx_i,
    .slot_addr_i, .slot_en_i, .retire_i, .pc_pre_i, .pc_post_i, .idle_i, .irq_i,
    .halt_o, .reason_o, .steps_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic retire(logic [15:0] pre, logic [15:0] post, logic idl, logic irq);
    @(negedge clk);
    retire_i = 1; pc_pre_i = pre; pc_post_i = post; idle_i = idl; irq_i = irq;
    @(negedge clk);
    retire_i = 0; idle_i = 0; irq_i = 0;
  endtask

  task automatic step_n(int n, logic [15:0] base);
    for (int i = 0; i < n; i++) retire(base + 16'(4*i), base + 16'(4*i+2), 0, 0);
  endtask

  task automatic do_clear();
    @(negedge clk); clear_i = 1;
    @(negedge clk); clear_i = 0;
  endtask

  task automatic set_limit(logic [31:0] v);
    @(negedge clk); lim_we_i = 1; lim_i = v;
    @(negedge clk); lim_we_i = 0;
  endtask

  task automatic set_slot(logic [1:0] idx, logic [15:0] a, logic en);
    @(negedge clk); slot_we_i = 1; slot_idx_i = idx; slot_addr_i = a; slot_en_i = en;
    @(negedge clk); slot_we_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 halt", halt_o, 0);
    chk("R1 reason", reason_o, 0);
    chk("R1 steps", steps_o, 0);
    // disabled slots: pc 0 matches reset addresses but must not stop
    retire(16'h0000, 16'h0002, 0, 0);
    chk("R1 slots disabled", halt_o, 0);
    do_clear();
  endtask

  task automatic t_count();
    step_n(3, 16'h1000);
    chk("R2 steps", steps_o, 3);
    chk("R2 no halt", halt_o, 0);
    do_clear();
  endtask

  task automatic t_max();
    set_limit(4);
    step_n(3, 16'h1100);
    chk("R3 before limit", halt_o, 0);
    retire(16'h1200, 16'h1202, 0, 0);
    chk("R3 halt", halt_o, 1);
    chk("R3 reason", reason_o, 3);
    chk("R3 steps", steps_o, 4);
    retire(16'h1300, 16'h1300, 0, 0);
    chk("R10 reason held", reason_o, 3);
    chk("R10 steps held", steps_o, 4);
    do_clear();
    chk("R11 halt cleared", halt_o, 0);
    chk("R11 steps cleared", steps_o, 0);
    step_n(4, 16'h1400);
    chk("R11 limit kept", {halt_o, reason_o}, 3'b111);
    do_clear();
    set_limit(1000);
  endtask

  task automatic t_stop();
    set_slot(2, 16'h0100, 1);
    set_slot(1, 16'h0200, 0);
    step_n(2, 16'h2000);
    retire(16'h0200, 16'h0202, 0, 0);
    chk("R5 disabled slot", halt_o, 0);
    chk("R5 counted", steps_o, 3);
    retire(16'h0100, 16'h0102, 0, 0);
    chk("R4 halt", halt_o, 1);
    chk("R4 reason", reason_o, 1);
    chk("R4 not counted", steps_o, 3);
    do_clear();
  endtask

  task automatic t_loop();
    step_n(1, 16'h3000);
    retire(16'h0040, 16'h0040, 0, 0);
    chk("R6 reason", {halt_o, reason_o}, 3'b110);
    chk("R6 counted", steps_o, 2);
    do_clear();
  endtask

  task automatic t_idle();
    retire(16'h4000, 16'h4002, 1, 0);
    chk("R7 window open", halt_o, 0);
    @(negedge clk);
    chk("R7 idle halt", {halt_o, reason_o}, 3'b100);
    chk("R7 steps", steps_o, 1);
    do_clear();
    // wake together with the idle retire
    retire(16'h4100, 16'h4102, 1, 1);
    @(negedge clk); @(negedge clk);
    chk("R8 irq at retire", halt_o, 0);
    // wake during the window
    retire(16'h4200, 16'h4202, 1, 0);
    irq_i = 1;
    @(negedge clk); irq_i = 0;
    @(negedge clk);
    chk("R8 irq in window", halt_o, 0);
    retire(16'h4300, 16'h4302, 0, 0);
    chk("R8 resumes", steps_o, 3);
    do_clear();
  endtask

  task automatic t_priority();
    retire(16'h0100, 16'h0100, 0, 0);
    chk("R9 stop over loop", {halt_o, reason_o}, 3'b101);
    do_clear();
    retire(16'h5000, 16'h5000, 1, 0);
    chk("R9 loop over idle", {halt_o, reason_o}, 3'b110);
    do_clear();
    set_limit(3);
    step_n(2, 16'h5100);
    retire(16'h5200, 16'h5202, 1, 0);
    chk("R9 idle+max pending", halt_o, 0);
    @(negedge clk);
    chk("R9 idle over max", {halt_o, reason_o}, 3'b100);
    do_clear();
    step_n(2, 16'h5300);
    retire(16'h5400, 16'h5402, 1, 0);
    irq_i = 1;
    @(negedge clk); irq_i = 0;
    chk("R9 woken idle gives max", {halt_o, reason_o}, 3'b111);
    chk("R9 steps", steps_o, 3);
    do_clear();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_max();
    t_stop();
    t_loop();
    t_idle();
    t_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule